// File: doc/BRIEF.md
# Pixel Gain-Offset Saturating Unit

This block rescales a stream of 8-bit unsigned pixels one at a time. Each pixel is multiplied by a signed 16-bit gain, the product is divided by a signed 16-bit divisor, a signed 8-bit offset is added, and the sum is clamped into the range 0 to 255. All intermediate arithmetic is held in a 32-bit signed value. Pixels are independent of one another, so the unit can sit inline in any pixel path.

Pixels enter through a valid/ready handshake and results leave through a second valid/ready handshake. The three coefficients are held in internal registers loaded through a write strobe. A register stage computes the product. An iterative divider produces one quotient bit per cycle. An output stage applies the offset and the clamp. The block stalls from the output backward when the output is blocked. A zero divisor produces a zero result and raises an error flag that stays set until reset.

Top module: `psu_top`

## Requirements
- R1: For a nonzero divisor, the output equals trunc(pixel*gain/divisor)+offset when that value lies in 0..255.
- R2: When trunc(pixel*gain/divisor)+offset is negative, the output is 0.
- R3: When trunc(pixel*gain/divisor)+offset exceeds 255, the output is 255.
- R4: The quotient of the signed divide rounds toward zero, not toward minus infinity. For example, -7/2 gives -3.
- R5: A pixel processed with a divisor of 0 produces output 0, whatever the offset.
- R6: `div_err` goes high no later than the output of the first pixel processed with a zero divisor. It then stays high until reset. Before any such pixel it is low.
- R7: Results leave in the order the pixels were accepted, one result per accepted pixel. No result is lost or duplicated under any pattern of `out_ready`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pixel` does not change on the next cycle.
- R9: A write (`cfg_we` high at a clock edge) affects only pixels accepted at later edges. A pixel accepted at the same edge as the write uses the previous coefficients.
- R10: After reset, `out_valid` and `div_err` are low, `in_ready` is high, and the coefficients are gain 1, divisor 1 and offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pixel | input | 8 | Unsigned input pixel |
| cfg_we | input | 1 | Coefficient register write strobe |
| cfg_gain | input | 16 | Signed gain to write |
| cfg_div | input | 16 | Signed divisor to write |
| cfg_off | input | 8 | Signed offset to write |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_pixel | output | 8 | Clamped unsigned result |
| div_err | output | 1 | Sticky zero-divisor flag |

## Verification
The coefficient write and the acceptance of a pixel can land on the same clock edge. The bench provokes this by pulsing `cfg_we` exactly in the cycle a pixel handshake completes, and again on the following pixel. The first pixel is judged against a reference built from the old coefficients and the second against the new ones. Randomised `out_ready` stalls the output while the divider finishes, so a finished quotient and a blocked output coincide. Every result is compared in order against a queue filled at acceptance time.

// File: rtl/psu_pkg.sv
package psu_pkg;
    localparam int PIX_W  = 8;
    localparam int COEF_W = 16;
    localparam int OFF_W  = 8;
    localparam int ACC_W  = 32;
    localparam int CNT_W  = $clog2(ACC_W + 1);
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef struct packed {
        logic signed [ACC_W-1:0]  prod;
        logic signed [COEF_W-1:0] dvsr;
        logic signed [OFF_W-1:0]  off;
    } mul_tok_t;

    typedef struct packed {
        logic signed [ACC_W-1:0] quo;
        logic signed [OFF_W-1:0] off;
        logic                    dz;
    } div_tok_t;

    typedef enum logic [1:0] {DV_IDLE, DV_RUN, DV_DONE} dv_state_t;

    function automatic logic [ACC_W-1:0] mag_acc(input logic signed [ACC_W-1:0] v);
        return v[ACC_W-1] ? ACC_W'(-v) : ACC_W'(v);
    endfunction

    function automatic logic [COEF_W-1:0] mag_coef(input logic signed [COEF_W-1:0] v);
        return v[COEF_W-1] ? COEF_W'(-v) : COEF_W'(v);
    endfunction

    function automatic logic [PIX_W-1:0] sat_pix(input logic signed [ACC_W-1:0] v);
        if (v < 0)
            return '0;
        else if (v > PIX_MAX)
            return PIX_W'(PIX_MAX);
        else
            return v[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/psu_mul_stage.sv
module psu_mul_stage
    import psu_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [PIX_W-1:0]         in_pixel,
    input  logic signed [COEF_W-1:0] gain,
    input  logic signed [COEF_W-1:0] dvsr,
    input  logic signed [OFF_W-1:0]  off,
    output logic                     tok_valid,
    output mul_tok_t                 tok,
    input  logic                     tok_take
);
    logic signed [ACC_W-1:0] pix_ext;
    logic signed [ACC_W-1:0] gain_ext;
    logic                    vld_q;
    mul_tok_t                tok_q;

    assign pix_ext  = {{(ACC_W-PIX_W){1'b0}}, in_pixel};
    assign gain_ext = {{(ACC_W-COEF_W){gain[COEF_W-1]}}, gain};
    assign in_ready = !vld_q || tok_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            tok_q <= '0;
        end else if (in_ready) begin
            vld_q <= in_valid;
            if (in_valid) begin
                tok_q.prod <= pix_ext * gain_ext;
                tok_q.dvsr <= dvsr;
                tok_q.off  <= off;
            end
        end
    end

    assign tok_valid = vld_q;
    assign tok       = tok_q;

    AST_MUL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !tok_take) |=> (vld_q && $stable(tok_q))); // R7
endmodule

// File: rtl/psu_divider.sv
module psu_divider
    import psu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tok_valid,
    input  mul_tok_t tok,
    output logic     tok_take,
    output logic     res_valid,
    output div_tok_t res,
    input  logic     res_take
);
    dv_state_t               st_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [COEF_W:0]         rem_q;
    logic [ACC_W-1:0]        quo_q;
    logic [COEF_W-1:0]       dmag_q;
    logic                    neg_q;
    logic                    dz_q;
    logic signed [OFF_W-1:0] off_q;
    logic [COEF_W:0]         shifted;
    logic                    fits;

    assign tok_take = tok_valid && (st_q == DV_IDLE);
    assign shifted  = {rem_q[COEF_W-1:0], quo_q[ACC_W-1]};
    assign fits     = shifted >= {1'b0, dmag_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= DV_IDLE;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            dmag_q <= '0;
            neg_q  <= 1'b0;
            dz_q   <= 1'b0;
            off_q  <= '0;
        end else begin
            case (st_q)
                DV_IDLE: begin
                    if (tok_valid) begin
                        off_q <= tok.off;
                        rem_q <= '0;
                        if (tok.dvsr == '0) begin
                            dz_q  <= 1'b1;
                            quo_q <= '0;
                            neg_q <= 1'b0;
                            st_q  <= DV_DONE;
                        end else begin
                            dz_q   <= 1'b0;
                            quo_q  <= mag_acc(tok.prod);
                            dmag_q <= mag_coef(tok.dvsr);
                            neg_q  <= tok.prod[ACC_W-1] ^ tok.dvsr[COEF_W-1];
                            cnt_q  <= CNT_W'(ACC_W);
                            st_q   <= DV_RUN;
                        end
                    end
                end
                DV_RUN: begin
                    rem_q <= fits ? (shifted - {1'b0, dmag_q}) : shifted;
                    quo_q <= {quo_q[ACC_W-2:0], fits};
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1))
                        st_q <= DV_DONE;
                end
                DV_DONE: begin
                    if (res_take)
                        st_q <= DV_IDLE;
                end
                default: st_q <= DV_IDLE;
            endcase
        end
    end

    assign res_valid = (st_q == DV_DONE);
    assign res.quo   = neg_q ? -$signed(quo_q) : $signed(quo_q);
    assign res.off   = off_q;
    assign res.dz    = dz_q;

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == DV_DONE && !dz_q) |-> (rem_q < {1'b0, dmag_q})); // R4
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q == DV_DONE && !res_take) |=> (st_q == DV_DONE && $stable(quo_q))); // R7
endmodule

// File: rtl/psu_out_stage.sv
module psu_out_stage
    import psu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  div_tok_t         res,
    output logic             res_take,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pixel,
    output logic             div_err
);
    logic signed [ACC_W-1:0] sum;
    logic                    ov_q;
    logic [PIX_W-1:0]        px_q;
    logic                    err_q;

    assign sum      = res.quo + {{(ACC_W-OFF_W){res.off[OFF_W-1]}}, res.off};
    assign res_take = res_valid && (!ov_q || out_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q  <= 1'b0;
            px_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (res_take) begin
                ov_q <= 1'b1;
                px_q <= res.dz ? '0 : sat_pix(sum);
                if (res.dz)
                    err_q <= 1'b1;
            end else if (out_ready) begin
                ov_q <= 1'b0;
            end
        end
    end

    assign out_valid = ov_q;
    assign out_pixel = px_q;
    assign div_err   = err_q;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ov_q && !out_ready) |=> (ov_q && $stable(px_q))); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R6
    AST_DZ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_take && res.dz) |=> (px_q == '0 && err_q)); // R5
endmodule

// File: rtl/psu_top.sv
module psu_top
    import psu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_pixel,
    input  logic        cfg_we,
    input  logic [15:0] cfg_gain,
    input  logic [15:0] cfg_div,
    input  logic [7:0]  cfg_off,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_pixel,
    output logic        div_err
);
    logic signed [COEF_W-1:0] gain_q;
    logic signed [COEF_W-1:0] div_q;
    logic signed [OFF_W-1:0]  off_q;
    logic                     m_valid;
    mul_tok_t                 m_tok;
    logic                     m_take;
    logic                     d_valid;
    div_tok_t                 d_res;
    logic                     d_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= COEF_W'(1);
            div_q  <= COEF_W'(1);
            off_q  <= '0;
        end else if (cfg_we) begin
            gain_q <= cfg_gain;
            div_q  <= cfg_div;
            off_q  <= cfg_off;
        end
    end

    psu_mul_stage u_mul (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
        .gain(gain_q), .dvsr(div_q), .off(off_q),
        .tok_valid(m_valid), .tok(m_tok), .tok_take(m_take)
    );

    psu_divider u_div (
        .clk(clk), .rst(rst),
        .tok_valid(m_valid), .tok(m_tok), .tok_take(m_take),
        .res_valid(d_valid), .res(d_res), .res_take(d_take)
    );

    psu_out_stage u_out (
        .clk(clk), .rst(rst),
        .res_valid(d_valid), .res(d_res), .res_take(d_take),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_pixel(out_pixel), .div_err(div_err)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !div_err && in_ready)); // R10
endmodule

// File: tb/psu_top_tb_top.sv
`timescale 1ns/1ps
module psu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_pixel = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_gain = '0;
    logic [15:0] cfg_div = '0;
    logic [7:0]  cfg_off = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_pixel;
    logic        div_err;

    always #2.5 clk = ~clk;

    psu_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .cfg_we(cfg_we), .cfg_gain(cfg_gain),
        .cfg_div(cfg_div), .cfg_off(cfg_off), .out_valid(out_valid),
        .out_ready(out_ready), .out_pixel(out_pixel), .div_err(div_err)
    );

    typedef struct {
        int    val;
        bit    dz;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    m_gain = 1, m_div = 1, m_off = 0;
    bit    err_exp = 1'b0;
    bit    last_acc;
    bit    hold_prev = 1'b0;
    logic [7:0] hold_px;
    int    n_in = 0, n_outp = 0;
    string force_tag = "";

    task automatic check(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    function automatic exp_t model(input int p, input int g, input int d, input int o);
        exp_t e;
        int raw;
        e.dz = (d == 0);
        if (e.dz) begin
            e.val = 0;
            e.tag = "R5";
        end else begin
            raw = (p * g) / d + o;
            if (raw < 0) begin e.val = 0; e.tag = "R2"; end
            else if (raw > 255) begin e.val = 255; e.tag = "R3"; end
            else begin
                e.val = raw;
                e.tag = (((p * g) % d) != 0 && ((p * g < 0) != (d < 0))) ? "R4" : "R1";
            end
        end
        return e;
    endfunction

    task automatic step(input bit v, input logic [7:0] p, input bit rdy, input bit we,
                        input logic [15:0] g, input logic [15:0] d, input logic [7:0] o);
        exp_t e;
        @(negedge clk);
        in_valid  = v;
        in_pixel  = p;
        out_ready = rdy;
        cfg_gain  = g;
        cfg_div   = d;
        cfg_off   = o;
        cfg_we    = we && (!v || in_ready);
        #2;
        if (hold_prev) begin
            check("R8", {31'd0, out_valid}, 1);
            check("R8", int'(out_pixel), int'(hold_px));
        end
        hold_prev = out_valid && !out_ready;
        hold_px   = out_pixel;
        if (out_valid && out_ready) begin
            n_outp++;
            if (q.size() == 0) begin
                check("R7", 1, 0);
            end else begin
                e = q.pop_front();
                if (e.dz) err_exp = 1'b1;
                check(e.tag, int'(out_pixel), e.val);
                check("R6", {31'd0, div_err}, {31'd0, err_exp});
            end
        end
        last_acc = in_valid && in_ready;
        if (last_acc) begin
            n_in++;
            e = model(int'(p), m_gain, m_div, m_off);
            if (force_tag != "") e.tag = force_tag;
            q.push_back(e);
        end
        if (cfg_we) begin
            m_gain = int'($signed(g));
            m_div  = int'($signed(d));
            m_off  = int'($signed(o));
        end
        @(posedge clk);
    endtask

    task automatic send(input logic [7:0] p, input bit we, input int g, input int d, input int o);
        do step(1'b1, p, 1'b1, we, 16'(g), 16'(d), 8'(o)); while (!last_acc);
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && q.size() != 0; i++)
            step(1'b0, 8'd0, 1'b1, 1'b0, 16'd0, 16'd0, 8'd0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #900000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd7321);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R10 reset state
        check("R10", {31'd0, out_valid}, 0);
        check("R10", {31'd0, div_err}, 0);
        check("R10", {31'd0, in_ready}, 1);
        @(posedge clk);
        // R10: default coefficients are identity
        send(8'd123, 1'b0, 0, 0, 0);
        q[q.size()-1].tag = "R10";
        drain();
        // R1 plain scaling
        send(8'd0, 1'b1, 3, 4, 5);
        send(8'd200, 1'b0, 0, 0, 0);
        // R2 negative intermediate
        send(8'd0, 1'b1, -3, 1, 0);
        send(8'd50, 1'b0, 0, 0, 0);
        // R3 above range
        send(8'd0, 1'b1, 2, 1, 0);
        send(8'd200, 1'b0, 0, 0, 0);
        // R4 truncation toward zero: -7/2 = -3, +10 = 7
        send(8'd0, 1'b1, -1, 2, 10);
        send(8'd7, 1'b0, 0, 0, 0);
        send(8'd0, 1'b1, 1, -2, 10);
        send(8'd7, 1'b0, 0, 0, 0);
        drain();
        // R9: write coincides with acceptance
        force_tag = "R9";
        send(8'd40, 1'b1, 1, 1, 100);
        send(8'd40, 1'b1, 2, 1, 0);
        send(8'd40, 1'b0, 0, 0, 0);
        force_tag = "";
        // R7 random with backpressure
        for (int i = 0; i < 700; i++) begin
            int g, d, o;
            bit we;
            g  = int'($urandom_range(1200)) - 600;
            d  = int'($urandom_range(400)) - 200;
            if (d == 0) d = 7;
            if ($urandom_range(9) == 0) d = 32767 - int'($urandom_range(3));
            o  = int'($urandom_range(255)) - 128;
            we = ($urandom_range(7) == 0);
            step($urandom_range(1) == 1, 8'($urandom_range(255)), $urandom_range(3) != 0,
                 we, 16'(g), 16'(d), 8'(o));
        end
        // long stall then release
        send(8'd10, 1'b1, 5, 3, 1);
        for (int i = 0; i < 120; i++)
            step(i < 40, 8'(i * 7), 1'b0, 1'b0, 16'd0, 16'd0, 8'd0);
        drain();
        check("R6", {31'd0, div_err}, 0);
        // R5/R6 zero divisor
        send(8'd99, 1'b1, 5, 0, 77);
        send(8'd1, 1'b0, 0, 0, 0);
        drain();
        check("R6", {31'd0, div_err}, 1);
        send(8'd30, 1'b1, 2, 3, 0);
        send(8'd30, 1'b0, 0, 0, 0);
        drain();
        check("R6", {31'd0, div_err}, 1);
        check("R7", q.size(), 0);
        check("R7", n_outp, n_in);
        finish_run();
    end
endmodule